// File: doc/BRIEF.md
# Shared I/O Port Slice with Peripheral Override

This block is one slice of a general-purpose parallel I/O port whose pins are also wanted by an on-chip peripheral. A small register bus reaches three registers: a direction register, an output latch and a read-only view of the synchronized pin levels. Each pin has its own output multiplexer. When the peripheral that shares the pin is both enabled and actively driving it, the peripheral's data and output enable reach the pad. Otherwise the port's latch and direction bit control the pad.

Pin levels pass through a two-flop synchronizer. The synchronized value feeds the port read path and the peripheral input, and nothing else does. So the pad output can never loop straight back into the peripheral. An implemented-bit mask parameter removes pins that do not exist in a given configuration. Those bits store nothing, read as zero and never drive their pads.

Top module: `shared_io_port`

## Requirements
- R1: After reset, every implemented direction bit is 1 (input), the output latch is 0 and no pad output enable is asserted.
- R2: When the port owns a pin, a direction bit of 0 asserts padOe and drives padOut from the latch bit. A direction bit of 1 deasserts padOe.
- R3: A write to address 2 loads the output latch, and a read of address 2 returns the latch.
- R4: A read of address 1 returns the pin levels two clock edges after they are applied. A write to address 1 loads the output latch and does not change what address 1 reads.
- R5: When periphEn and periphDrive are both 1 for a pin, padOut and padOe for that pin follow periphOut and periphOe, whatever the port registers hold.
- R6: While the peripheral owns a pin, that pin's level can still be read through address 1.
- R7: When periphEn is 1 but periphDrive is 0, the pin's pad follows the port latch and direction bit.
- R8: Bits cleared in IMPL_MASK read as 0 from addresses 0, 1 and 2, ignore writes, and hold padOe and padOut at 0.
- R9: periphIn carries the synchronized pin level and not the pad output value.
- R10: Reads are combinational from the registers in the cycle the address is presented. A write takes effect at the next clock edge.
- R11: Address 3 reads as 0, and writes to it change no register.
- R12: Address 0 reads and writes the direction register, masked by IMPL_MASK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address: 0 direction, 1 pins, 2 latch, 3 unused |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | WIDTH | Write data |
| busRdData | output | WIDTH | Combinational read data for busAddr |
| padIn | input | WIDTH | Asynchronous pin levels from the pads |
| padOut | output | WIDTH | Data to the pad drivers |
| padOe | output | WIDTH | Output enable to the pad drivers (1 = drive) |
| periphEn | input | WIDTH | Peripheral enabled, per pin |
| periphDrive | input | WIDTH | Peripheral actively driving, per pin |
| periphOut | input | WIDTH | Peripheral output data |
| periphOe | input | WIDTH | Peripheral output enable |
| periphIn | output | WIDTH | Synchronized pin levels to the peripheral |

## Verification
A write to the pin-read address can arrive in the same cycle as a change in the pin levels. The bench applies both at one falling edge. It then expects the latch to hold the written data after one edge, and the pin read to show the new pad value after two edges, not the written data. Ownership changes are also set up in the same cycle as latch and direction writes, and every pad bit is judged against the owner that the enable and drive inputs select.

// File: rtl/shared_io_pkg.sv
package shared_io_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_PIN  = 2'd1,
    REG_OUT  = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    dirWr;
    logic    outWr;
    regSel_e rdSel;
  } busStrobe_t;
endpackage

// File: rtl/shared_io_ctrl.sv
module shared_io_ctrl
  import shared_io_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobe_t        strobe
);
  regSel_e sel;

  always_comb begin
    sel          = regSel_e'(busAddr);
    strobe.rdSel = sel;
    strobe.dirWr = 1'b0;
    strobe.outWr = 1'b0;
    unique case (sel)
      REG_DIR:  strobe.dirWr = busWrEn;
      REG_PIN:  strobe.outWr = busWrEn;   // pin address writes land in the latch
      REG_OUT:  strobe.outWr = busWrEn;
      REG_NONE: ;
      default:  ;
    endcase
  end
endmodule

// File: rtl/shared_io_datapath.sv
module shared_io_datapath
  import shared_io_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'hBF
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strobe,
  input  logic [WIDTH-1:0] busWrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] busRdData,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] latchQ,
  output logic [WIDTH-1:0] pinSync
);
  logic [WIDTH-1:0] syncA;
  logic [WIDTH-1:0] syncB;
  logic [1:0]       warm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ   <= IMPL_MASK;
      latchQ <= '0;
    end else begin
      if (strobe.dirWr) dirQ   <= busWrData & IMPL_MASK;
      if (strobe.outWr) latchQ <= busWrData & IMPL_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      warm  <= '0;
    end else begin
      syncA <= padIn & IMPL_MASK;
      syncB <= syncA;
      if (warm != 2'd2) warm <= warm + 2'd1;
    end
  end

  assign pinSync = syncB;

  always_comb begin
    unique case (strobe.rdSel)
      REG_DIR:  busRdData = dirQ;
      REG_PIN:  busRdData = pinSync;
      REG_OUT:  busRdData = latchQ;
      default:  busRdData = '0;
    endcase
  end

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dirWr |=> dirQ == ($past(busWrData) & IMPL_MASK)); // R12
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.outWr |=> latchQ == ($past(busWrData) & IMPL_MASK)); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dirWr |=> $stable(dirQ)); // R11
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.outWr |=> $stable(latchQ)); // R11
  AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2) |-> pinSync == ($past(padIn, 2) & IMPL_MASK)); // R4
  AST_READ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData & ~IMPL_MASK) == '0); // R8
endmodule

// File: rtl/shared_io_padmux.sv
module shared_io_padmux #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'hBF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dirQ,
  input  logic [WIDTH-1:0] latchQ,
  input  logic [WIDTH-1:0] pinSync,
  input  logic [WIDTH-1:0] periphEn,
  input  logic [WIDTH-1:0] periphDrive,
  input  logic [WIDTH-1:0] periphOut,
  input  logic [WIDTH-1:0] periphOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] periphIn
);
  for (genvar i = 0; i < WIDTH; i++) begin : gPin
    if (IMPL_MASK[i]) begin : gLive
      logic periphOwns;
      assign periphOwns  = periphEn[i] & periphDrive[i];
      assign padOut[i]   = periphOwns ? periphOut[i] : latchQ[i];
      assign padOe[i]    = periphOwns ? periphOe[i]  : ~dirQ[i];
      assign periphIn[i] = pinSync[i];
    end else begin : gDead
      assign padOut[i]   = 1'b0;
      assign padOe[i]    = 1'b0;
      assign periphIn[i] = 1'b0;
    end
  end

  logic [WIDTH-1:0] ownChk;
  logic [WIDTH-1:0] portChk;
  assign ownChk  = periphEn & periphDrive & IMPL_MASK;
  assign portChk = ~(periphEn & periphDrive) & IMPL_MASK;

  AST_PERIPH_OWNS: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe ^ periphOe) | (padOut ^ periphOut)) & ownChk) == '0); // R5
  AST_PORT_OWNS: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe ^ ~dirQ) | (padOut ^ latchQ)) & portChk) == '0); // R7
  AST_UNIMPL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padOut) & ~IMPL_MASK) == '0); // R8
  AST_NO_LOOP: assert property (@(posedge clk) disable iff (!rstN)
    periphIn == pinSync); // R9
endmodule

// File: rtl/shared_io_port.sv
module shared_io_port
  import shared_io_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'hBF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  input  logic [WIDTH-1:0]  periphEn,
  input  logic [WIDTH-1:0]  periphDrive,
  input  logic [WIDTH-1:0]  periphOut,
  input  logic [WIDTH-1:0]  periphOe,
  output logic [WIDTH-1:0]  periphIn
);
  busStrobe_t       strobe;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] latchQ;
  logic [WIDTH-1:0] pinSync;

  shared_io_ctrl uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  shared_io_datapath #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWrData (busWrData),
    .padIn     (padIn),
    .busRdData (busRdData),
    .dirQ      (dirQ),
    .latchQ    (latchQ),
    .pinSync   (pinSync)
  );

  shared_io_padmux #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) uMux (
    .clk         (clk),
    .rstN        (rstN),
    .dirQ        (dirQ),
    .latchQ      (latchQ),
    .pinSync     (pinSync),
    .periphEn    (periphEn),
    .periphDrive (periphDrive),
    .periphOut   (periphOut),
    .periphOe    (periphOe),
    .padOut      (padOut),
    .padOe       (padOe),
    .periphIn    (periphIn)
  );
endmodule

// File: tb/shared_io_port_test.sv
module shared_io_port_test;
  localparam int         W    = 8;
  localparam logic [7:0] MASK = 8'hBF;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   busAddr = '0;
  logic         busWrEn = 1'b0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] busRdData;
  logic [W-1:0] padIn = '0;
  logic [W-1:0] padOut, padOe, periphIn;
  logic [W-1:0] periphEn = '0, periphDrive = '0, periphOut = '0, periphOe = '0;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] expDir, expLatch;

  always #10 clk = ~clk;

  shared_io_port #(.WIDTH(W), .IMPL_MASK(MASK)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .periphEn(periphEn),
    .periphDrive(periphDrive), .periphOut(periphOut), .periphOe(periphOe),
    .periphIn(periphIn)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [W-1:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [W-1:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  function automatic logic [W-1:0] expPadOe(input logic [W-1:0] dir);
    logic [W-1:0] own = periphEn & periphDrive;
    return ((periphOe & own) | (~dir & ~own)) & MASK;
  endfunction

  function automatic logic [W-1:0] expPadOut(input logic [W-1:0] lat);
    logic [W-1:0] own = periphEn & periphDrive;
    return ((periphOut & own) | (lat & ~own)) & MASK;
  endfunction

  task automatic testReset();
    logic [W-1:0] v;
    busRead(2'd0, v); check("R1 dir after reset", v, MASK);
    busRead(2'd2, v); check("R1 latch after reset", v, 8'h00);
    check("R1 padOe after reset", padOe, 8'h00);
  endtask

  task automatic testLatch();
    logic [W-1:0] v;
    busWrite(2'd2, 8'hFF);
    busRead(2'd2, v); check("R3/R8 latch masked", v, MASK);
    busAddr = 2'd2; busWrData = 8'h5A; busWrEn = 1'b1; #1;
    check("R10 read before edge", busRdData, MASK);
    @(posedge clk); @(negedge clk); busWrEn = 1'b0;
    check("R10 read after edge", busRdData, 8'h5A & MASK);
    expLatch = 8'h5A & MASK;
  endtask

  task automatic testDir();
    logic [W-1:0] v;
    busWrite(2'd0, 8'h00); expDir = 8'h00;
    busRead(2'd0, v); check("R12 dir readback", v, 8'h00);
    check("R2 all outputs oe", padOe, MASK);
    check("R2 padOut from latch", padOut, expLatch);
    busWrite(2'd0, 8'hF0); expDir = 8'hF0 & MASK;
    busRead(2'd0, v); check("R12 dir readback masked", v, expDir);
    check("R2 mixed direction", padOe, ~expDir & MASK);
  endtask

  task automatic testPinRead();
    logic [W-1:0] v;
    busRead(2'd1, v); check("R4 pins idle", v, 8'h00);
    padIn = 8'hC3;
    @(posedge clk); @(negedge clk);
    busRead(2'd1, v); check("R4 one edge not yet", v, 8'h00);
    @(posedge clk); @(negedge clk);
    busRead(2'd1, v); check("R4 two edges", v, 8'hC3 & MASK);
    busWrite(2'd1, 8'h3C); expLatch = 8'h3C & MASK;
    busRead(2'd1, v); check("R4 pin write not seen on pins", v, 8'hC3 & MASK);
    busRead(2'd2, v); check("R4 pin write lands in latch", v, expLatch);
  endtask

  task automatic testPeriph();
    logic [W-1:0] v;
    busWrite(2'd0, 8'h00); expDir = 8'h00;
    periphEn = 8'h0F; periphDrive = 8'h05; periphOut = 8'hFF; periphOe = 8'h01; #1;
    check("R5 padOe with owner", padOe, expPadOe(expDir));
    check("R5 padOut with owner", padOut, expPadOut(expLatch));
    check("R7 enabled not driving bit1", {7'd0, padOut[1]}, {7'd0, expLatch[1]});
    padIn = 8'h55;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    busRead(2'd1, v); check("R6 pin readable under owner", v, 8'h55 & MASK);
    check("R9 periphIn is pin level", periphIn, 8'h55 & MASK);
    periphDrive = 8'h00; #1;
    check("R7 port regains pads oe", padOe, ~expDir & MASK);
    check("R7 port regains pads data", padOut, expLatch);
    periphEn = 8'h00; periphOut = 8'h00; periphOe = 8'h00;
  endtask

  task automatic testUnused();
    logic [W-1:0] v;
    busRead(2'd3, v); check("R11 unused reads zero", v, 8'h00);
    busWrite(2'd3, 8'hA5);
    busRead(2'd0, v); check("R11 dir untouched", v, expDir);
    busRead(2'd2, v); check("R11 latch untouched", v, expLatch);
    periphEn = 8'hFF; periphDrive = 8'hFF; periphOut = 8'hFF; periphOe = 8'hFF; #1;
    check("R8 dead pad oe", padOe & ~MASK, 8'h00);
    check("R8 dead pad out", padOut & ~MASK, 8'h00);
    periphEn = 8'h00; periphDrive = 8'h00; periphOut = 8'h00; periphOe = 8'h00;
  endtask

  task automatic testCollide();
    logic [W-1:0] v;
    padIn = 8'hAA; busAddr = 2'd1; busWrData = 8'h11; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk); busWrEn = 1'b0;
    busRead(2'd2, v); check("R4 collide latch", v, 8'h11);
    expLatch = 8'h11;
    @(posedge clk); @(negedge clk);
    busRead(2'd1, v); check("R4 collide pins", v, 8'hAA & MASK);
    check("R9 collide periphIn", periphIn, 8'hAA & MASK);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    expDir = MASK; expLatch = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLatch();
    testDir();
    testPinRead();
    testPeriph();
    testUnused();
    testCollide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule